// File: doc/BRIEF.md
# SECDED ECC Memory Wrapper

This block sits in front of a synchronous single-port SRAM whose words are 39 bits wide: 32 data bits, six Hamming check bits and one overall parity bit. Every write encodes the check bits from the data. Every read recomputes the syndrome. The block corrects a single flipped bit and reports a double flip without changing the data. Reads are requested on a simple request/write-enable port and their result comes back with a valid strobe one cycle later.

The block keeps one error record for single-bit events and one for double-bit events. Each record has a sticky flag and an 11-bit failing-address register. Each flag has its own interrupt enable, and the two enabled flags are combined into one interrupt line. A small configuration write port sets the control bits, the interrupt enables, the write-1-to-clear bits and the key field. Software may set the ECC enable at any time. Clearing it takes a two-byte key sequence.

While the ECC enable is off, writes update only the data bits and leave the stored check bits as they were. Software uses this to plant a known fault and then read it back with ECC on.

Top module: `ecc_mem_wrap`

## Requirements
- R1: After synchronous reset the following are all 0: the ECC enable, the address-latch enable, both interrupt enables, both flags, both failing addresses, `irq` and `rd_valid`.
- R2: A read requested in cycle T (`mem_req`=1, `mem_we`=0) sets `rd_valid` for exactly cycle T+1. With ECC on and an intact word, `rd_data` equals the last data written to that address, and neither `rd_single` nor `rd_double` is raised.
- R3: With ECC on, a stored word with one flipped data bit returns the corrected data with `rd_single`=1. `err_single` is 1 from the following cycle.
- R4: With ECC on, a stored word with two flipped data bits returns the uncorrected stored data with `rd_double`=1 and `rd_single`=0. `err_double` is 1 from the following cycle.
- R5: Stored word layout: bits [31:0] hold data, [37:32] hold Hamming checks over data positions 1..38 (check bits sit at the power-of-two positions), and [38] holds the parity of the other 38 bits. The syndrome and the overall parity classify a read: a zero syndrome with even parity is clean, odd parity is a single error, and a nonzero syndrome with even parity is a double error. A double error never sets `err_single`.
- R6: `irq` = (`err_single` AND single enable) OR (`err_double` AND double enable). Both enables are in the register at `cfg_sel`=1: bit 0 is the single enable and bit 1 is the double enable.
- R7: The control register is at `cfg_sel`=0, with bit 4 the address-latch enable. When an error sets a flag while the address-latch enable is 1, that error's failing-address output takes the word address, zero-extended to 11 bits. When the enable is 0, the failing-address output keeps its old value.
- R8: While a flag is set, a new error of the same type leaves its failing address unchanged.
- R9: A write at `cfg_sel`=2 clears `err_single` where bit 0 is 1 and `err_double` where bit 1 is 1. An error that arrives in the same cycle as the clear wins, and the flag stays 1.
- R10: ECC enable is bit 0 of the control register, and writing 1 to it always sets it. It falls to 0 only through a control write that follows writing 0xAE and then 0x75 to the key field at `cfg_sel`=3. Any other key byte re-locks. Any control write also re-locks.
- R11: While ECC is off, writes replace only the data bits. Reads return the raw data with no error indication and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read data, corrected when possible |
| rd_single | output | 1 | This read had a corrected single error |
| rd_double | output | 1 | This read had an uncorrectable double error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 interrupt enable, 2 clear, 3 key |
| cfg_wdata | input | 8 | Configuration write data |
| ecc_en | output | 1 | Current ECC enable |
| err_single | output | 1 | Sticky single-error flag |
| err_double | output | 1 | Sticky double-error flag |
| fail_addr_single | output | 11 | Address of the latched single error |
| fail_addr_double | output | 11 | Address of the latched double error |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong syndrome or wrong correction logic shows up as bad `rd_data` or a bad error strobe in the cycle after the read request. Faults planted through the check-bit-preserving write path expose it at once. A flag or address register in the wrong state shows on `err_*`, `fail_addr_*` or `irq` one cycle after the read, or right after the configuration write that changes it. A key sequencer in the wrong state shows as `ecc_en` failing to fall, or falling without a valid key, in the cycle after the control write.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

    localparam int DATA_W  = 32;
    localparam int CHK_W   = 6;
    localparam int WORD_W  = DATA_W + CHK_W + 1;
    localparam int FAIL_AW = 11;
    localparam int HAM_TOP = DATA_W + CHK_W;

    localparam logic [7:0] KEY_FIRST  = 8'hAE;
    localparam logic [7:0] KEY_SECOND = 8'h75;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_KEY  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single;
        logic              dbl;
    } dec_t;

    // Hamming position (1..38) of data bit i; power-of-two slots are skipped
    function automatic logic [CHK_W-1:0] data_pos(input int i);
        int cnt;
        int pos;
        cnt = -1;
        pos = 0;
        for (int p = 1; p <= HAM_TOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                cnt++;
                if (cnt == i) pos = p;
            end
        end
        return pos[CHK_W-1:0];
    endfunction

    function automatic logic [CHK_W-1:0] ham_check(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        logic [CHK_W-1:0] pos;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos = data_pos(i);
            for (int k = 0; k < CHK_W; k++) begin
                if (pos[k]) c[k] = c[k] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        c = ham_check(d);
        return {^{c, d}, c, d};
    endfunction

    function automatic dec_t ecc_decode(input logic [WORD_W-1:0] w);
        dec_t             r;
        logic [CHK_W-1:0] syn;
        logic             odd;
        syn      = ham_check(w[DATA_W-1:0]) ^ w[HAM_TOP-1:DATA_W];
        odd      = ^w;
        r.data   = w[DATA_W-1:0];
        r.single = 1'b0;
        r.dbl    = 1'b0;
        if (odd) begin
            r.single = 1'b1;
            for (int i = 0; i < DATA_W; i++) begin
                if (data_pos(i) == syn) r.data[i] = ~w[i];
            end
        end else if (syn != '0) begin
            r.dbl = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_sram.sv
module ecc_sram
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              req,
    input  logic              we,
    input  logic              wr_chk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (req) begin
            if (we) begin
                mem[addr][DATA_W-1:0] <= wword[DATA_W-1:0];
                if (wr_chk) mem[addr][WORD_W-1:DATA_W] <= wword[WORD_W-1:DATA_W];
            end else begin
                rword <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/ecc_key_guard.sv
module ecc_key_guard
    import ecc_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic       ecc_en,
    output logic       ale,
    output logic       se_en,
    output logic       de_en,
    output logic       key_open
);
    key_state_e kstate;

    assign key_open = (kstate == KS_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            kstate <= KS_LOCKED;
            ecc_en <= 1'b0;
            ale    <= 1'b0;
            se_en  <= 1'b0;
            de_en  <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    ale <= cfg_wdata[4];
                    if (cfg_wdata[0])  ecc_en <= 1'b1;
                    else if (key_open) ecc_en <= 1'b0;
                    kstate <= KS_LOCKED;
                end
                SEL_IEN: begin
                    se_en <= cfg_wdata[0];
                    de_en <= cfg_wdata[1];
                end
                SEL_KEY: begin
                    if (cfg_wdata == KEY_FIRST)
                        kstate <= KS_HALF;
                    else if (kstate == KS_HALF && cfg_wdata == KEY_SECOND)
                        kstate <= KS_OPEN;
                    else
                        kstate <= KS_LOCKED;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ecc_err_slot.sv
module ecc_err_slot
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               event_i,
    input  logic               clear_i,
    input  logic               ale_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               flag_o,
    output logic [FAIL_AW-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            addr_o <= '0;
        end else if (event_i) begin
            if (!flag_o && ale_i) addr_o <= FAIL_AW'(addr_i);
            flag_o <= 1'b1;
        end else if (clear_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_mem_wrap.sv
module ecc_mem_wrap
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_req,
    input  logic               mem_we,
    input  logic [ADDR_W-1:0]  mem_addr,
    input  logic [31:0]        mem_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               rd_single,
    output logic               rd_double,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    output logic               ecc_en,
    output logic               err_single,
    output logic               err_double,
    output logic [FAIL_AW-1:0] fail_addr_single,
    output logic [FAIL_AW-1:0] fail_addr_double,
    output logic               irq
);
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] raw_word;
    logic              rvalid_q;
    logic              rchk_q;
    logic [ADDR_W-1:0] raddr_q;
    dec_t              dec;
    logic              ale, se_en, de_en, key_open;
    logic [1:0]        ev_vec, clr_vec, flag_vec;
    logic [FAIL_AW-1:0] fail_vec [2];

    assign wr_word = ecc_encode(mem_wdata);

    ecc_sram #(.ADDR_W(ADDR_W)) u_sram (
        .clk    (clk),
        .req    (mem_req),
        .we     (mem_we),
        .wr_chk (ecc_en),
        .addr   (mem_addr),
        .wword  (wr_word),
        .rword  (raw_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rchk_q   <= 1'b0;
            raddr_q  <= '0;
        end else begin
            rvalid_q <= mem_req & ~mem_we;
            if (mem_req && !mem_we) begin
                raddr_q <= mem_addr;
                rchk_q  <= ecc_en;
            end
        end
    end

    assign dec       = ecc_decode(raw_word);
    assign rd_valid  = rvalid_q;
    assign rd_data   = rchk_q ? dec.data : raw_word[DATA_W-1:0];
    assign rd_single = rvalid_q & rchk_q & dec.single;
    assign rd_double = rvalid_q & rchk_q & dec.dbl;

    ecc_key_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ecc_en    (ecc_en),
        .ale       (ale),
        .se_en     (se_en),
        .de_en     (de_en),
        .key_open  (key_open)
    );

    assign ev_vec  = {rd_double, rd_single};
    assign clr_vec = (cfg_we && cfg_sel == SEL_CLR) ? cfg_wdata[1:0] : 2'b00;

    for (genvar g = 0; g < 2; g++) begin : g_slot
        ecc_err_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .event_i (ev_vec[g]),
            .clear_i (clr_vec[g]),
            .ale_i   (ale),
            .addr_i  (raddr_q),
            .flag_o  (flag_vec[g]),
            .addr_o  (fail_vec[g])
        );
    end

    assign err_single       = flag_vec[0];
    assign err_double       = flag_vec[1];
    assign fail_addr_single = fail_vec[0];
    assign fail_addr_double = fail_vec[1];
    assign irq              = (flag_vec[0] & se_en) | (flag_vec[1] & de_en);

endmodule

// File: rtl/ecc_mem_wrap_chk.sv
module ecc_mem_wrap_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_valid,
    input logic        rd_single,
    input logic        rd_double,
    input logic        err_single,
    input logic        err_double,
    input logic [10:0] fail_addr_single,
    input logic [10:0] fail_addr_double,
    input logic        ecc_en,
    input logic        key_open,
    input logic [1:0]  clr_vec,
    input logic        irq
);
    // R2
    no_status_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!rd_single && !rd_double));

    // R5
    single_double_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_single, rd_double}));

    // R3
    single_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_single |=> err_single);

    // R4
    double_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_double |=> err_double);

    // R8
    single_addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        err_single |=> $stable(fail_addr_single));

    // R8
    double_addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        err_double |=> $stable(fail_addr_double));

    // R9
    single_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_single && !clr_vec[0]) |=> err_single);

    // R9
    double_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_double && !clr_vec[1]) |=> err_double);

    // R10
    enable_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (ecc_en && !key_open) |=> ecc_en);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_single && !err_double) |-> !irq);

endmodule

bind ecc_mem_wrap ecc_mem_wrap_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .rd_valid         (rd_valid),
    .rd_single        (rd_single),
    .rd_double        (rd_double),
    .err_single       (err_single),
    .err_double       (err_double),
    .fail_addr_single (fail_addr_single),
    .fail_addr_double (fail_addr_double),
    .ecc_en           (ecc_en),
    .key_open         (key_open),
    .clr_vec          (clr_vec),
    .irq              (irq)
);

// File: tb/ecc_mem_wrap_tb.sv
module ecc_mem_wrap_tb;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mem_req = 1'b0, mem_we = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [31:0]       mem_wdata = '0;
    logic              rd_valid, rd_single, rd_double;
    logic [31:0]       rd_data;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              ecc_en, err_single, err_double, irq;
    logic [10:0]       fail_addr_single, fail_addr_double;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic [31:0] d;
        logic        s;
        logic        dd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    ecc_mem_wrap #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_single(rd_single), .rd_double(rd_double),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ecc_en(ecc_en), .err_single(err_single), .err_double(err_double),
        .fail_addr_single(fail_addr_single), .fail_addr_double(fail_addr_double),
        .irq(irq)
    );

    // monitor: compare every read result against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected rd_valid, got data %h expected no result", rd_data);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e.d || rd_single !== e.s || rd_double !== e.dd) begin
                    fails++;
                    $display("FAIL %s: got data %h s %b d %b expected data %h s %b d %b",
                             t, rd_data, rd_single, rd_double, e.d, e.s, e.dd);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mem_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic mem_read(input logic [ADDR_W-1:0] a, input logic [31:0] ed,
                            input logic es, input logic edd, input string tag);
        exp_q.push_back('{d: ed, s: es, dd: edd});
        tag_q.push_back(tag);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
        @(negedge clk);
        mem_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key_unlock();
        cfg_write(2'd3, 8'hAE);
        cfg_write(2'd3, 8'h75);
    endtask

    // store good data with checks, then overwrite data only with bad
    task automatic inject(input logic [ADDR_W-1:0] a, input logic [31:0] good,
                          input logic [31:0] bad, input logic ale);
        cfg_write(2'd0, {3'b000, ale, 3'b000, 1'b1});
        mem_write(a, good);
        key_unlock();
        cfg_write(2'd0, {3'b000, ale, 3'b000, 1'b0});
        mem_write(a, bad);
        cfg_write(2'd0, {3'b000, ale, 3'b000, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 err_single", {31'd0, err_single}, 32'd0);
        check("R1 err_double", {31'd0, err_double}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 ecc_en", {31'd0, ecc_en}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R1 fail_addr_single", {21'd0, fail_addr_single}, 32'd0);
        check("R1 fail_addr_double", {21'd0, fail_addr_double}, 32'd0);

        cfg_write(2'd0, 8'h11);
        check("R10 enable set", {31'd0, ecc_en}, 32'd1);

        mem_write(8'h05, 32'hDEADBEEF);
        mem_write(8'h00, 32'h00000000);
        mem_write(8'hFF, 32'hFFFFFFFF);
        mem_write(8'h20, 32'hA5A5A5A5);
        mem_write(8'h09, 32'h12345678);
        mem_write(8'h30, 32'h0F0F0F0F);
        mem_read(8'h05, 32'hDEADBEEF, 1'b0, 1'b0, "R2");
        mem_read(8'h00, 32'h00000000, 1'b0, 1'b0, "R2");
        mem_read(8'hFF, 32'hFFFFFFFF, 1'b0, 1'b0, "R2");
        mem_read(8'h20, 32'hA5A5A5A5, 1'b0, 1'b0, "R2");
        mem_read(8'h09, 32'h12345678, 1'b0, 1'b0, "R2");
        idle(2);
        check("R2 no flag after clean reads", {30'd0, err_double, err_single}, 32'd0);

        // ECC off: data-only write, raw read
        key_unlock();
        cfg_write(2'd0, 8'h10);
        check("R10 enable cleared after key", {31'd0, ecc_en}, 32'd0);
        mem_write(8'h05, 32'hDEADBEEF ^ 32'h00000080);
        mem_read(8'h05, 32'hDEADBEEF ^ 32'h00000080, 1'b0, 1'b0, "R11");
        idle(2);
        check("R11 no flag with ECC off", {30'd0, err_double, err_single}, 32'd0);

        // single error
        cfg_write(2'd0, 8'h11);
        mem_read(8'h05, 32'hDEADBEEF, 1'b1, 1'b0, "R3 R5");
        idle(1);
        check("R3 err_single", {31'd0, err_single}, 32'd1);
        check("R7 fail_addr_single", {21'd0, fail_addr_single}, 32'h5);
        check("R6 irq masked", {31'd0, irq}, 32'd0);
        cfg_write(2'd1, 8'h01);
        check("R6 irq single", {31'd0, irq}, 32'd1);

        // sticky: second single error does not move address
        inject(8'h09, 32'h12345678, 32'h12345678 ^ 32'h00010000, 1'b1);
        mem_read(8'h09, 32'h12345678, 1'b1, 1'b0, "R8 R3");
        idle(1);
        check("R8 fail_addr_single frozen", {21'd0, fail_addr_single}, 32'h5);

        cfg_write(2'd2, 8'h01);
        check("R9 clear single", {31'd0, err_single}, 32'd0);
        check("R6 irq after clear", {31'd0, irq}, 32'd0);

        // double error
        inject(8'h20, 32'hA5A5A5A5, 32'hA5A5A5A5 ^ 32'h80000001, 1'b1);
        mem_read(8'h20, 32'hA5A5A5A5 ^ 32'h80000001, 1'b0, 1'b1, "R4 R5");
        idle(1);
        check("R4 err_double", {31'd0, err_double}, 32'd1);
        check("R5 double leaves single flag", {31'd0, err_single}, 32'd0);
        check("R7 fail_addr_double", {21'd0, fail_addr_double}, 32'h20);
        check("R6 irq double masked", {31'd0, irq}, 32'd0);
        cfg_write(2'd1, 8'h03);
        check("R6 irq double", {31'd0, irq}, 32'd1);

        // wrong keys
        cfg_write(2'd3, 8'hAE);
        cfg_write(2'd3, 8'h12);
        cfg_write(2'd3, 8'h75);
        cfg_write(2'd0, 8'h10);
        check("R10 wrong key keeps enable", {31'd0, ecc_en}, 32'd1);
        cfg_write(2'd0, 8'h00);
        check("R10 no key keeps enable", {31'd0, ecc_en}, 32'd1);
        key_unlock();
        cfg_write(2'd0, 8'h11);
        cfg_write(2'd0, 8'h10);
        check("R10 control write relocks", {31'd0, ecc_en}, 32'd1);

        cfg_write(2'd2, 8'h02);
        check("R9 clear double", {31'd0, err_double}, 32'd0);

        // address latch disabled
        inject(8'h30, 32'h0F0F0F0F, 32'h0F0F0F0F ^ 32'h00004000, 1'b0);
        mem_read(8'h30, 32'h0F0F0F0F, 1'b1, 1'b0, "R7 R3");
        idle(1);
        check("R7 flag without latch", {31'd0, err_single}, 32'd1);
        check("R7 address not latched", {21'd0, fail_addr_single}, 32'h5);

        // set and clear in the same cycle
        cfg_write(2'd2, 8'h01);
        check("R9 cleared before race", {31'd0, err_single}, 32'd0);
        mem_read(8'h30, 32'h0F0F0F0F, 1'b1, 1'b0, "R9 R3");
        cfg_write(2'd2, 8'h01);
        check("R9 set wins over clear", {31'd0, err_single}, 32'd1);

        // double error at top address
        inject(8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFC, 1'b1);
        mem_read(8'hFF, 32'hFFFFFFFC, 1'b0, 1'b1, "R4");
        idle(1);
        check("R7 fail_addr_double top", {21'd0, fail_addr_double}, 32'hFF);

        idle(3);
        check("R2 all reads returned", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule